// File: doc/BRIEF.md
# Vector Float Greater-Than Comparator with Predicate Accumulation

This block compares two packed vectors of IEEE floating-point values lane by lane and reports, for every lane, whether the lane of the first vector is greater than the matching lane of the second. The format select chooses 32-bit single-precision lanes or 16-bit half-precision lanes. The comparison uses a fixed total order in which NaNs are ordered and never unordered. In that order, positive NaNs rank above +Inf, negative NaNs rank below -Inf, and a quiet NaN ranks further from zero than a signalling NaN of the same sign. The order is exactly a sign-magnitude integer compare of the raw bit patterns.

Each lane result is spread over one predicate bit per data byte. The spread predicate then either replaces an incoming predicate or is merged into it by AND, OR or XOR. The same strobe also drives a byte mux. For each byte, the mux takes the byte of the first vector where the incoming predicate bit is set and the byte of the second vector otherwise. Both results are registered on the clock edge at which the valid strobe is high. A two-state machine keeps track of whether the outputs show a fresh result:

- `ST_IDLE`: nothing new. It moves to `ST_SHOW` on the transition `capture`, which is an edge with `in_valid` high.
- `ST_SHOW`: a fresh result is present. It stays in `ST_SHOW` on another `capture`. It returns to `ST_IDLE` on the transition `expire`, which is an edge with `in_valid` low.

Top module: `vec_fcmp_pred`

## Requirements
- R1: With `fmt_half`=0, lane i occupies vector bits [32i+31:32i]. A lane is greater exactly when the following order holds, from highest to lowest: positive QNaN (0x7FC00000) > positive SNaN (0x7FA00000) > +Inf (0x7F800000) > finite values > -Inf (0xFF800000) > negative SNaN (0xFFA00000) > negative QNaN (0xFFC00000). Finite values follow their numeric order.
- R2: With `fmt_half`=1, lane j occupies vector bits [16j+15:16j] and follows the same order. The half-precision encodings are +Inf 0x7C00, -Inf 0xFC00, QNaN 0x7E00, SNaN 0x7D00, negative SNaN 0xFD00 and negative QNaN 0xFE00.
- R3: Identical bit patterns compare false in both formats, including two identical SNaNs. +0 (all zero) compares greater than -0 (sign bit only) in both formats.
- R4: The compare predicate has one bit per byte. A true single-precision lane i sets bits 4i to 4i+3. A true half-precision lane j sets bits 2j and 2j+1. A false lane clears those bits.
- R5: `op_sel`=00 (write) makes `pred_out` equal to the compare predicate.
- R6: `op_sel`=01 (AND) makes `pred_out` equal to `pred_in` AND the compare predicate.
- R7: `op_sel`=10 (OR) makes `pred_out` equal to `pred_in` OR the compare predicate.
- R8: `op_sel`=11 (XOR) makes `pred_out` equal to `pred_in` XOR the compare predicate.
- R9: Byte k of `vec_out` is byte k of `vec_a` when `pred_in[k]` is 1, and byte k of `vec_b` otherwise.
- R10: `pred_out` and `vec_out` load on a rising edge with `in_valid` high and hold on any other edge. `out_valid` is high in the cycle after a loading edge and low after an edge with `in_valid` low.
- R11: While `rst_n` is low, `pred_out`, `vec_out` and `out_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe that loads a new result |
| fmt_half | input | 1 | 0 = single-precision lanes, 1 = half-precision lanes |
| op_sel | input | 2 | 00 write, 01 AND, 10 OR, 11 XOR |
| vec_a | input | 8*VEC_BYTES | First operand vector, and the mux choice for set predicate bits |
| vec_b | input | 8*VEC_BYTES | Second operand vector, and the mux choice for clear predicate bits |
| pred_in | input | VEC_BYTES | Incoming predicate, used for accumulation and as the mux select |
| pred_out | output | VEC_BYTES | Registered accumulated predicate |
| vec_out | output | 8*VEC_BYTES | Registered byte-mux result |
| out_valid | output | 1 | High while the outputs hold a fresh result |

## Verification
The bench builds the block with `VEC_BYTES`=16. This gives four single-precision lanes or eight half-precision lanes, so one vector can hold a complete chain of the total order, from QNaN down to negative QNaN. The predicate is then 16 bits wide and can be written out as a literal. With this size, every special encoding, the equal-operand and signed-zero cases, and each of the four accumulation codes against a known old predicate can be checked exactly. Random patterns mixed with the special encodings then cover sign and magnitude combinations in both lane widths.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_AND   = 2'b01,
        OP_OR    = 2'b10,
        OP_XOR   = 2'b11
    } acc_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } out_state_e;

endpackage

// File: rtl/fcmp_lane_gt.sv
module fcmp_lane_gt #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         gt
);
    localparam int MW = W - 1;

    logic          sa;
    logic          sb;
    logic [MW-1:0] ma;
    logic [MW-1:0] mb;

    assign sa = a[W-1];
    assign sb = b[W-1];
    assign ma = a[MW-1:0];
    assign mb = b[MW-1:0];

    // Sign-magnitude order: signs decide first; among negatives the
    // larger magnitude is the smaller value.
    always_comb begin
        if (sa != sb) begin
            gt = ~sa;
        end else if (sa) begin
            gt = (ma < mb);
        end else begin
            gt = (ma > mb);
        end
    end
endmodule

// File: rtl/pred_merge.sv
module pred_merge
    import vfc_pkg::*;
#(
    parameter int PW = 128
) (
    input  acc_op_e        op,
    input  logic [PW-1:0]  old_pred,
    input  logic [PW-1:0]  cmp_pred,
    output logic [PW-1:0]  new_pred
);
    always_comb begin
        unique case (op)
            OP_WRITE: new_pred = cmp_pred;
            OP_AND:   new_pred = old_pred & cmp_pred;
            OP_OR:    new_pred = old_pred | cmp_pred;
            OP_XOR:   new_pred = old_pred ^ cmp_pred;
            default:  new_pred = cmp_pred;
        endcase
    end
endmodule

// File: rtl/byte_mux.sv
module byte_mux #(
    parameter int NB = 128
) (
    input  logic [NB-1:0]   sel,
    input  logic [8*NB-1:0] in_one,
    input  logic [8*NB-1:0] in_zero,
    output logic [8*NB-1:0] out
);
    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign out[8*k +: 8] = sel[k] ? in_one[8*k +: 8] : in_zero[8*k +: 8];
    end
endmodule

// File: rtl/vec_fcmp_pred.sv
module vec_fcmp_pred
    import vfc_pkg::*;
#(
    parameter int VEC_BYTES = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   fmt_half,
    input  logic [1:0]             op_sel,
    input  logic [8*VEC_BYTES-1:0] vec_a,
    input  logic [8*VEC_BYTES-1:0] vec_b,
    input  logic [VEC_BYTES-1:0]   pred_in,
    output logic [VEC_BYTES-1:0]   pred_out,
    output logic [8*VEC_BYTES-1:0] vec_out,
    output logic                   out_valid
);
    localparam int VW       = 8 * VEC_BYTES;
    localparam int SF_LANES = VEC_BYTES / 4;
    localparam int HF_LANES = VEC_BYTES / 2;

    logic [VEC_BYTES-1:0] sf_pred;
    logic [VEC_BYTES-1:0] hf_pred;
    logic [VEC_BYTES-1:0] cmp_pred;
    logic [VEC_BYTES-1:0] merged;
    logic [VW-1:0]        muxed;
    acc_op_e              op;
    out_state_e           state_q;
    out_state_e           state_d;

    assign op = acc_op_e'(op_sel);

    for (genvar i = 0; i < SF_LANES; i++) begin : g_sf
        logic gt;
        fcmp_lane_gt #(.W(32)) u_lane (
            .a  (vec_a[32*i +: 32]),
            .b  (vec_b[32*i +: 32]),
            .gt (gt)
        );
        assign sf_pred[4*i +: 4] = {4{gt}};
    end

    for (genvar j = 0; j < HF_LANES; j++) begin : g_hf
        logic gt;
        fcmp_lane_gt #(.W(16)) u_lane (
            .a  (vec_a[16*j +: 16]),
            .b  (vec_b[16*j +: 16]),
            .gt (gt)
        );
        assign hf_pred[2*j +: 2] = {2{gt}};
    end

    assign cmp_pred = fmt_half ? hf_pred : sf_pred;

    pred_merge #(.PW(VEC_BYTES)) u_merge (
        .op       (op),
        .old_pred (pred_in),
        .cmp_pred (cmp_pred),
        .new_pred (merged)
    );

    byte_mux #(.NB(VEC_BYTES)) u_mux (
        .sel     (pred_in),
        .in_one  (vec_a),
        .in_zero (vec_b),
        .out     (muxed)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: capture / expire
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_out <= '0;
            vec_out  <= '0;
        end else if (in_valid) begin
            pred_out <= merged;
            vec_out  <= muxed;
        end
    end

    assign out_valid = (state_q == ST_SHOW);
endmodule

// File: rtl/vec_fcmp_pred_chk.sv
module vec_fcmp_pred_chk #(
    parameter int VEC_BYTES = 128
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   fmt_half,
    input logic [1:0]             op_sel,
    input logic [VEC_BYTES-1:0]   pred_in,
    input logic [VEC_BYTES-1:0]   pred_out,
    input logic [8*VEC_BYTES-1:0] vec_out,
    input logic                   out_valid
);
    logic quads_ok;
    logic pairs_ok;

    always_comb begin
        quads_ok = 1'b1;
        for (int q = 0; q < VEC_BYTES / 4; q++) begin
            if (pred_out[4*q +: 4] != 4'h0 && pred_out[4*q +: 4] != 4'hF) quads_ok = 1'b0;
        end
        pairs_ok = 1'b1;
        for (int p = 0; p < VEC_BYTES / 2; p++) begin
            if (pred_out[2*p] != pred_out[2*p+1]) pairs_ok = 1'b0;
        end
    end

    assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_expire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pred_out) && $stable(vec_out)));

    assert_sf_quads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_half && op_sel == 2'b00) |=> quads_ok);

    assert_hf_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_half && op_sel == 2'b00) |=> pairs_ok);

    assert_and_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b01) |=> ((pred_out & ~$past(pred_in)) == '0));

    assert_or_superset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b10) |=> ((pred_out & $past(pred_in)) == $past(pred_in)));
endmodule

bind vec_fcmp_pred vec_fcmp_pred_chk #(.VEC_BYTES(VEC_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .fmt_half  (fmt_half),
    .op_sel    (op_sel),
    .pred_in   (pred_in),
    .pred_out  (pred_out),
    .vec_out   (vec_out),
    .out_valid (out_valid)
);

// File: tb/vec_fcmp_pred_tb.sv
`timescale 1ns/1ps
module vec_fcmp_pred_tb;
    localparam int NB = 16;
    localparam int VW = 8 * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          fmt_half = 1'b0;
    logic [1:0]    op_sel = 2'b00;
    logic [VW-1:0] vec_a = '0;
    logic [VW-1:0] vec_b = '0;
    logic [NB-1:0] pred_in = '0;
    logic [NB-1:0] pred_out;
    logic [VW-1:0] vec_out;
    logic          out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vec_fcmp_pred #(.VEC_BYTES(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_half(fmt_half),
        .op_sel(op_sel), .vec_a(vec_a), .vec_b(vec_b), .pred_in(pred_in),
        .pred_out(pred_out), .vec_out(vec_out), .out_valid(out_valid)
    );

    task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Order keys: unsigned compare of keys equals the total order.
    function automatic logic [31:0] key32(logic [31:0] x);
        return x[31] ? ~x : (x ^ 32'h8000_0000);
    endfunction
    function automatic logic [15:0] key16(logic [15:0] x);
        return x[15] ? ~x : (x ^ 16'h8000);
    endfunction

    function automatic logic [NB-1:0] model_pred(logic [VW-1:0] a, logic [VW-1:0] b,
                                                 logic half, logic [1:0] op,
                                                 logic [NB-1:0] old);
        logic [NB-1:0] c = '0;
        if (half) begin
            for (int j = 0; j < NB / 2; j++)
                if (key16(a[16*j +: 16]) > key16(b[16*j +: 16])) c[2*j +: 2] = 2'b11;
        end else begin
            for (int i = 0; i < NB / 4; i++)
                if (key32(a[32*i +: 32]) > key32(b[32*i +: 32])) c[4*i +: 4] = 4'hF;
        end
        case (op)
            2'b00:   return c;
            2'b01:   return old & c;
            2'b10:   return old | c;
            default: return old ^ c;
        endcase
    endfunction

    function automatic logic [VW-1:0] model_mux(logic [VW-1:0] a, logic [VW-1:0] b,
                                                logic [NB-1:0] s);
        logic [VW-1:0] r;
        for (int k = 0; k < NB; k++) r[8*k +: 8] = s[k] ? a[8*k +: 8] : b[8*k +: 8];
        return r;
    endfunction

    task automatic apply(logic half, logic [1:0] op, logic [VW-1:0] a,
                         logic [VW-1:0] b, logic [NB-1:0] old);
        @(negedge clk);
        fmt_half = half; op_sel = op; vec_a = a; vec_b = b; pred_in = old;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] pick32(int r);
        case (r % 10)
            0: return 32'h7FC0_0000;
            1: return 32'h7FA0_0000;
            2: return 32'h7F80_0000;
            3: return 32'hFF80_0000;
            4: return 32'hFFA0_0000;
            5: return 32'hFFC0_0000;
            6: return 32'h0000_0000;
            7: return 32'h8000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        logic [VW-1:0] a;
        logic [VW-1:0] b;
        logic [NB-1:0] old;
        logic [NB-1:0] ep;
        void'($urandom(32'd1234));
        #35;
        check("R11 reset pred_out", VW'(pred_out), '0);
        check("R11 reset vec_out", vec_out, '0);
        check("R11 reset out_valid", VW'(out_valid), '0);
        @(negedge clk); rst_n = 1'b1;

        // R1: full sf chain, each lane greater
        a = {32'hFF80_0000, 32'h7F80_0000, 32'h7FA0_0000, 32'h7FC0_0000};
        b = {32'hFFA0_0000, 32'h3F80_0000, 32'h7F80_0000, 32'h7FA0_0000};
        apply(1'b0, 2'b00, a, b, '0);
        check("R1 sf chain true", VW'(pred_out), VW'(16'hFFFF));
        check("R10 out_valid after capture", VW'(out_valid), 1);
        apply(1'b0, 2'b00, b, a, '0);
        check("R1 sf chain swapped", VW'(pred_out), '0);
        a = {32'hFFA0_0000, 32'h3F80_0000, 32'hFFC0_0000, 32'hC00C_CCCD};
        b = {32'hFFC0_0000, 32'hFFC0_0000, 32'hFFA0_0000, 32'h400C_CCCD};
        apply(1'b0, 2'b00, a, b, '0);
        check("R1 sf negatives", VW'(pred_out), VW'(16'hFF00));

        // R2: hf chain, lane7 equal
        a = {16'h3C00, 16'h0000, 16'hFD00, 16'hFC00, 16'h3C00, 16'h7C00, 16'h7D00, 16'h7E00};
        b = {16'h3C00, 16'h8000, 16'hFE00, 16'hFD00, 16'hFC00, 16'h3C00, 16'h7C00, 16'h7D00};
        apply(1'b1, 2'b00, a, b, '0);
        check("R2 hf chain", VW'(pred_out), VW'(16'h3FFF));

        // R3: equality and signed zero
        a = {32'h0000_0000, 32'h8000_0000, 32'h7FA0_0000, 32'h400C_CCCD};
        b = {32'h8000_0000, 32'h8000_0000, 32'h7FA0_0000, 32'h400C_CCCD};
        apply(1'b0, 2'b00, a, b, '0);
        check("R3 sf equal / +0>-0", VW'(pred_out), VW'(16'hF000));
        a = {{6{16'h0000}}, 16'h0000, 16'h7D00};
        b = {{6{16'h0000}}, 16'h8000, 16'h7D00};
        apply(1'b1, 2'b00, a, b, '0);
        check("R3 hf equal / +0>-0", VW'(pred_out), VW'(16'h000C));

        // R4..R8: lane 1 true -> bits 4..7
        a = {64'h0, 32'h3F80_0000, 32'h0000_0000};
        b = {64'h0, 32'h0000_0000, 32'h3F80_0000};
        apply(1'b0, 2'b00, a, b, 16'hABCD);
        check("R4 R5 sf lane1 bits 4-7", VW'(pred_out), VW'(16'h00F0));
        apply(1'b0, 2'b01, a, b, 16'h00F0);
        check("R6 and", VW'(pred_out), VW'(16'h00F0));
        apply(1'b0, 2'b10, a, b, 16'h000F);
        check("R7 or", VW'(pred_out), VW'(16'h00FF));
        apply(1'b0, 2'b11, a, b, 16'h00FF);
        check("R8 xor", VW'(pred_out), VW'(16'h000F));

        // R9: mux
        a = {4{32'h1122_3344}};
        b = {4{32'hAABB_CCDD}};
        apply(1'b0, 2'b00, a, b, 16'hA5C3);
        check("R9 mux", vec_out, model_mux(a, b, 16'hA5C3));

        // R10: hold when in_valid low
        ep = pred_out;
        @(negedge clk);
        vec_a = '1; vec_b = '0; pred_in = '1; op_sel = 2'b10;
        @(negedge clk);
        check("R10 pred hold", VW'(pred_out), VW'(ep));
        check("R10 vec hold", vec_out, model_mux(a, b, 16'hA5C3));
        check("R10 out_valid expire", VW'(out_valid), 0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic half;
            logic [1:0] op;
            half = 1'($urandom);
            op = 2'($urandom);
            for (int i = 0; i < NB / 4; i++) begin
                a[32*i +: 32] = pick32($urandom);
                b[32*i +: 32] = ($urandom % 6 == 0) ? a[32*i +: 32] : pick32($urandom);
            end
            if (half && ($urandom % 2 == 0))
                for (int j = 0; j < NB / 2; j++) begin
                    a[16*j +: 16] = a[16*j +: 16] ^ 16'h8000;
                end
            old = NB'($urandom);
            apply(half, op, a, b, old);
            check(half ? "R2 R4 random hf" : "R1 R4 random sf", VW'(pred_out),
                  VW'(model_pred(a, b, half, op, old)));
            check("R9 random mux", vec_out, model_mux(a, b, old));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule